// File: doc/BRIEF.md
# Dual-Latch Input Capture Unit

This block is one input-capture channel. It copies a shared free-running counter value, supplied on `count_i`, into one of two capture registers. A capture is started by a pulse on either of two software trigger inputs, one per register, or by a qualified edge on the external input `ext_i`. A static select chooses which register an external edge loads. Before it reaches the edge detector, the external input can pass through a majority-free noise filter. The filter samples on a selectable divided clock and accepts a new level only after three equal samples. One filter code bypasses the filter entirely.

A status output shows which register was written last. A sticky interrupt request is raised by every capture. It is also raised by any change of the edge or filter configuration, because such a change can produce a false edge. Software removes the request with a clear pulse before it enables the interrupt. The interrupt output is the request gated by the enable.

Top module: `dual_capture`

## Requirements
- R1: A one-cycle pulse on `sw_trig0_i` loads `count_i`, as sampled at that clock edge, into `cap0_o`, which is visible after the edge.
- R2: A one-cycle pulse on `sw_trig1_i` loads `count_i` into `cap1_o` in the same way.
- R3: A qualified external edge loads `count_i` into `cap0_o` when `ext_dst_i`=0 and into `cap1_o` when `ext_dst_i`=1. `edge_sel_i` selects the qualifying edge: 00 is rising, 01 is falling, and 10 or 11 is both. An edge that is not selected leaves both registers unchanged.
- R4: `last_o` goes to 0 after a load of register 0 alone and to 1 after any load of register 1. When both registers load in the same cycle, `last_o` is 1.
- R5: With `flt_sel_i`=00 the filter is bypassed. A new level on `ext_i` is captured at the first clock edge that sees it.
- R6: With `flt_sel_i` set to 01, 10 or 11, the input is sampled every 2, 8 or 32 clocks. A level is accepted only after three consecutive equal samples, so a one-clock glitch never causes a capture.
- R7: `req_o` is set by every capture and stays set until a `req_clr_i` pulse clears it. When a set and a clear occur in the same cycle, the set wins.
- R8: Any change of `edge_sel_i` or `flt_sel_i` sets `req_o` on the next clock edge.
- R9: `irq_o` is 1 exactly when `req_o` and `irq_en_i` are both 1.
- R10: After reset, `cap0_o`, `cap1_o`, `last_o`, `req_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | CW | Shared counter value |
| ext_i | input | 1 | External capture input, synchronous to clk_i |
| ext_dst_i | input | 1 | Register loaded by an external edge (0 or 1) |
| edge_sel_i | input | 2 | Active edge: 00 rising, 01 falling, 1x both |
| flt_sel_i | input | 2 | Filter: 00 bypass, 01 /2, 10 /8, 11 /32 |
| sw_trig0_i | input | 1 | Software capture into register 0 |
| sw_trig1_i | input | 1 | Software capture into register 1 |
| req_clr_i | input | 1 | Clears the interrupt request |
| irq_en_i | input | 1 | Interrupt enable |
| cap0_o | output | CW | Capture register 0 |
| cap1_o | output | CW | Capture register 1 |
| last_o | output | 1 | Register written last (0 or 1) |
| req_o | output | 1 | Sticky interrupt request |
| irq_o | output | 1 | Gated interrupt |

## Verification
The assertions check four properties on every cycle. Each load stores the counter value of the previous cycle. The status bit follows the register that loaded, and register 1 wins a tie. The request rises after a configuration change and falls after a clear that no set opposes. The filtered level holds still between sample ticks. Only the bench scenarios can show the cycle-level effects: which edge qualifies in each edge mode, that a one-clock glitch is rejected, and how long the divide-by-32 filter takes to accept a level.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    FLT_OFF = 2'b00,
    FLT_D_A = 2'b01,
    FLT_D_B = 2'b10,
    FLT_D_C = 2'b11
  } flt_mode_e;
endpackage

// File: rtl/dc_filter.sv
module dc_filter #(
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 32,
  parameter int STAGES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  logic [1:0] sel_i,
  output logic       lvl_o
);
  import dc_pkg::*;
  localparam int PW = $clog2(DIV_C) + 1;

  logic [PW-1:0]     pre_q;
  logic [PW-1:0]     lim;
  logic [STAGES-1:0] sh_q, sh_nxt;
  logic              flt_q, bypass, tick;

  assign bypass = (flt_mode_e'(sel_i) == FLT_OFF);

  always_comb begin
    case (flt_mode_e'(sel_i))
      FLT_D_A: lim = PW'(DIV_A - 1);
      FLT_D_B: lim = PW'(DIV_B - 1);
      default: lim = PW'(DIV_C - 1);
    endcase
  end

  assign tick   = !bypass && (pre_q >= lim);
  assign sh_nxt = {sh_q[STAGES-2:0], raw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sh_q  <= '0;
      flt_q <= 1'b0;
    end else if (bypass) begin
      // track input so leaving bypass creates no false edge
      pre_q <= '0;
      sh_q  <= {STAGES{raw_i}};
      flt_q <= raw_i;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        sh_q <= sh_nxt;
        if (&sh_nxt)       flt_q <= 1'b1;
        else if (~|sh_nxt) flt_q <= 1'b0;
      end
    end
  end

  assign lvl_o = bypass ? raw_i : flt_q;

  p_hold_between_ticks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && !tick) |=> $stable(flt_q));
endmodule

// File: rtl/dc_edge.sv
module dc_edge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import dc_pkg::*;
  logic prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    case (edge_mode_e'(sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      default:   hit_o = rise | fall;
    endcase
  end

  p_no_hit_flat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == prev_q) |-> !hit_o);
endmodule

// File: rtl/dc_latches.sv
module dc_latches #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          ld0_i,
  input  logic          ld1_i,
  output logic [CW-1:0] cap0_o,
  output logic [CW-1:0] cap1_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap0_o <= '0;
      cap1_o <= '0;
      last_o <= 1'b0;
    end else begin
      if (ld0_i) cap0_o <= count_i;
      if (ld1_i) cap1_o <= count_i;
      // register 1 wins a simultaneous load
      if (ld1_i)      last_o <= 1'b1;
      else if (ld0_i) last_o <= 1'b0;
    end
  end

  p_load0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld0_i |=> cap0_o == $past(count_i));
  p_load1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_i |=> cap1_o == $past(count_i));
  p_last_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_i |=> last_o);
  p_last_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld0_i && !ld1_i) |=> !last_o);
endmodule

// File: rtl/dual_capture.sv
module dual_capture #(
  parameter int CW    = 16,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          ext_i,
  input  logic          ext_dst_i,
  input  logic [1:0]    edge_sel_i,
  input  logic [1:0]    flt_sel_i,
  input  logic          sw_trig0_i,
  input  logic          sw_trig1_i,
  input  logic          req_clr_i,
  input  logic          irq_en_i,
  output logic [CW-1:0] cap0_o,
  output logic [CW-1:0] cap1_o,
  output logic          last_o,
  output logic          req_o,
  output logic          irq_o
);
  logic       lvl, hit, ld0, ld1, cfg_chg, req_set, req_q;
  logic [1:0] edge_q, flt_q;

  dc_filter #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .STAGES(3)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ext_i), .sel_i(flt_sel_i), .lvl_o(lvl)
  );

  dc_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .sel_i(edge_sel_i), .hit_o(hit)
  );

  assign ld0 = sw_trig0_i | (hit & ~ext_dst_i);
  assign ld1 = sw_trig1_i | (hit &  ext_dst_i);

  dc_latches #(.CW(CW)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_i),
    .ld0_i(ld0), .ld1_i(ld1),
    .cap0_o(cap0_o), .cap1_o(cap1_o), .last_o(last_o)
  );

  // reconfiguration may glitch the edge path, so it raises a request
  assign cfg_chg = (edge_sel_i != edge_q) || (flt_sel_i != flt_q);
  assign req_set = ld0 | ld1 | cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      flt_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      edge_q <= edge_sel_i;
      flt_q  <= flt_sel_i;
      req_q  <= req_set | (req_q & ~req_clr_i);
    end
  end

  assign req_o = req_q;
  assign irq_o = req_q & irq_en_i;

  p_cfg_sets_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> req_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_clr_i && !req_set) |=> !req_o);
  p_irq_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && req_o));
endmodule

// File: tb/dual_capture_test.sv
module dual_capture_test;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          ext_i = 1'b0, ext_dst_i = 1'b0;
  logic [1:0]    edge_sel_i = 2'b00, flt_sel_i = 2'b00;
  logic          sw_trig0_i = 1'b0, sw_trig1_i = 1'b0;
  logic          req_clr_i = 1'b0, irq_en_i = 1'b0;
  logic [CW-1:0] cap0_o, cap1_o;
  logic          last_o, req_o, irq_o;

  always #10 clk_i = ~clk_i;

  dual_capture #(.CW(CW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_i), .ext_i(ext_i),
    .ext_dst_i(ext_dst_i), .edge_sel_i(edge_sel_i), .flt_sel_i(flt_sel_i),
    .sw_trig0_i(sw_trig0_i), .sw_trig1_i(sw_trig1_i), .req_clr_i(req_clr_i),
    .irq_en_i(irq_en_i), .cap0_o(cap0_o), .cap1_o(cap1_o), .last_o(last_o),
    .req_o(req_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [CW-1:0] c0;
    logic [CW-1:0] c1;
    logic          last;
    logic          req;
    logic          irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  logic [CW-1:0] c0e = '0, c1e = '0;
  logic          le = 1'b0, re = 1'b0;

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // driver side of the scoreboard
  task automatic expect_now(input string tag);
    exp_t e;
    e.c0 = c0e; e.c1 = c1e; e.last = le; e.req = re; e.irq = re & irq_en_i;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
  endtask

  task automatic clr_req(input string tag);
    req_clr_i = 1'b1; tick(); req_clr_i = 1'b0;
    re = 1'b0; expect_now(tag);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      exp_t  e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (cap0_o !== e.c0 || cap1_o !== e.c1 || last_o !== e.last ||
          req_o !== e.req || irq_o !== e.irq) begin
        n_fail++;
        $display("FAIL %s: got c0=%h c1=%h last=%b req=%b irq=%b exp c0=%h c1=%h last=%b req=%b irq=%b",
                 t, cap0_o, cap1_o, last_o, req_o, irq_o, e.c0, e.c1, e.last, e.req, e.irq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    expect_now("R10 reset state");

    count_i = 16'h1111; sw_trig0_i = 1'b1; tick(); sw_trig0_i = 1'b0;
    c0e = 16'h1111; le = 1'b0; re = 1'b1; expect_now("R1 sw capture 0");
    clr_req("R7 clear request");

    count_i = 16'h2222; sw_trig1_i = 1'b1; tick(); sw_trig1_i = 1'b0;
    c1e = 16'h2222; le = 1'b1; re = 1'b1; expect_now("R2 sw capture 1");
    clr_req("R7 clear after R2");

    count_i = 16'h3333; sw_trig0_i = 1'b1; sw_trig1_i = 1'b1; tick();
    sw_trig0_i = 1'b0; sw_trig1_i = 1'b0;
    c0e = 16'h3333; c1e = 16'h3333; le = 1'b1; re = 1'b1; expect_now("R4 both load status 1");
    count_i = 16'h4444; sw_trig0_i = 1'b1; tick(); sw_trig0_i = 1'b0;
    c0e = 16'h4444; le = 1'b0; expect_now("R4 status back to 0");

    irq_en_i = 1'b1; tick(); expect_now("R9 irq asserted");
    count_i = 16'h5050; sw_trig1_i = 1'b1; req_clr_i = 1'b1; tick();
    sw_trig1_i = 1'b0; req_clr_i = 1'b0;
    c1e = 16'h5050; le = 1'b1; re = 1'b1; expect_now("R7 set wins over clear");
    clr_req("R9 irq drops with request");
    irq_en_i = 1'b0;

    count_i = 16'h5555; ext_dst_i = 1'b0; ext_i = 1'b1; tick();
    c0e = 16'h5555; le = 1'b0; re = 1'b1; expect_now("R5 bypass rising capture");
    clr_req("R7 clear after R5");
    count_i = 16'h6666; ext_i = 1'b0; tick(); expect_now("R3 falling ignored in rise mode");

    edge_sel_i = 2'b01; tick(); re = 1'b1; expect_now("R8 edge select change");
    clr_req("R7 clear after R8");
    ext_dst_i = 1'b1; count_i = 16'h7777; ext_i = 1'b1; tick();
    expect_now("R3 rising ignored in fall mode");
    count_i = 16'h8888; ext_i = 1'b0; tick();
    c1e = 16'h8888; le = 1'b1; re = 1'b1; expect_now("R3 falling capture into 1");
    clr_req("R7 clear after fall");

    edge_sel_i = 2'b10; tick(); re = 1'b1; expect_now("R8 edge select both");
    clr_req("R7 clear both");
    ext_dst_i = 1'b0; count_i = 16'h9999; ext_i = 1'b1; tick();
    c0e = 16'h9999; le = 1'b0; re = 1'b1; expect_now("R3 both mode rise");
    count_i = 16'hAAAA; ext_i = 1'b0; tick();
    c0e = 16'hAAAA; expect_now("R3 both mode fall");
    clr_req("R7 clear both edges");

    flt_sel_i = 2'b01; tick(); re = 1'b1; expect_now("R8 filter select change");
    clr_req("R7 clear filter");
    count_i = 16'hBBBB; ext_i = 1'b1; tick(); ext_i = 1'b0;
    repeat (20) tick();
    expect_now("R6 glitch rejected");

    flt_sel_i = 2'b11; tick(); re = 1'b1; expect_now("R8 filter div32");
    clr_req("R7 clear div32");
    count_i = 16'hCCCC; ext_i = 1'b1;
    repeat (30) tick();
    expect_now("R6 div32 not yet accepted");
    repeat (120) tick();
    c0e = 16'hCCCC; le = 1'b0; re = 1'b1; expect_now("R6 div32 accepted");

    done = 1'b1;
    #50;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule